// File: doc/BRIEF.md
# Branch Voltage and Current Evaluator

This block closes the per-time-step loop of a fixed-topology circuit simulator. The nodal solver produces a voltage for each node of the network. A step-start pulse hands those voltages to this block, together with the history current and the conductance of every branch. The block first forms each branch voltage as the difference between the branch's two terminal nodes, using a connectivity table fixed at build time. It then forms each branch current as the conductance times that voltage plus the branch's history current. All values are signed fixed point, with a 34-bit word and 19 fractional bits. Any arithmetic result that falls outside the word range is clamped, and a sticky flag records that this happened.

The results stay on the outputs until the sequencer commits them. A commit copies the branch voltages and currents into a one-step delay bank. The bank's contents are the previous-step state that the history current updater reads when it forms the next step's history currents. On reset the bank is not zeroed: it loads a precomputed initial-state vector, so the first step starts from a consistent state.

Top module: `bre_branch_eval`

## Requirements
- R1: While reset is high and on the cycle after it, busy, res_valid and ovf_sticky are 0, and prev_v/prev_i hold the initial-state vectors INIT_VB/INIT_IB. Branch b of any packed vector occupies bits [b*34 +: 34].
- R2: Branch b's voltage equals V(from) minus V(to). The default table is: branch 0 runs 1→0, branch 1 runs 1→2, branch 2 runs 2→3, branch 3 runs 0→3. Node 0 is ground and contributes 0. Node k ≥ 1 is read from node_v bits [(k-1)*34 +: 34].
- R3: Branch b's current equals (g·v arithmetically shifted right by 19, i.e. rounded toward minus infinity) plus the history current h. Values are two's complement with 19 fractional bits.
- R4: A branch voltage or current whose exact value lies outside the 34-bit signed range is clamped to the largest or smallest word. ovf_sticky then rises and stays high until reset.
- R5: Take a step_go sampled high while idle at edge k. busy is high after edge k and after edge k+1. br_v holds the new voltages after edge k+1. br_i holds the new currents and res_valid is high after edge k+2, and busy is low again at that point.
- R6: The block captures node_v, hist_i and br_g at the accepting edge, so later changes to those inputs do not alter the step's results. A step_go raised while busy is ignored.
- R7: A step_commit sampled while res_valid is high loads br_v/br_i into prev_v/prev_i at that edge, and clears res_valid.
- R8: A step_commit sampled while res_valid is low leaves prev_v/prev_i unchanged.
- R9: While res_valid is high and neither step_go nor step_commit is sampled, res_valid, br_v and br_i hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the initial state |
| step_go | input | 1 | Start pulse; node voltages, history currents and conductances are valid |
| node_v | input | N_NODES*34 | Solved voltages of nodes 1..N_NODES |
| hist_i | input | N_BR*34 | History current of each branch for this step |
| br_g | input | N_BR*34 | Conductance of each branch |
| step_commit | input | 1 | Store the current results into the delay bank |
| busy | output | 1 | A step is being evaluated |
| res_valid | output | 1 | br_v and br_i hold an uncommitted result |
| br_v | output | N_BR*34 | Branch voltages of this step |
| br_i | output | N_BR*34 | Branch currents of this step |
| prev_v | output | N_BR*34 | Stored branch voltages of the previous step |
| prev_i | output | N_BR*34 | Stored branch currents of the previous step |
| ovf_sticky | output | 1 | Sticky flag: a clamp has occurred since reset |

## Verification
Counting from the edge that accepts step_go, the branch voltages are due one edge later. The currents and res_valid are due two edges later. The delay bank changes on the same edge that samples step_commit. The driver raises step_go at a falling edge and then samples at each of the following falling edges: busy after the first, br_v after the second, and res_valid with busy low after the third. After each commit it checks the bank at the next falling edge. The monitor pops the expected voltages and currents when res_valid rises, and it compares at that falling edge. No value is read before the edge that produces it.

// File: rtl/bre_pkg.sv
package bre_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_VOLT = 2'd1,
    PH_CURR = 2'd2
  } bre_phase_e;
endpackage

// File: rtl/bre_volt_stage.sv
module bre_volt_stage #(
  parameter int unsigned W       = 34,
  parameter int unsigned N_NODES = 3,
  parameter int unsigned N_BR    = 4,
  parameter int unsigned IDX_W   = 4,
  parameter logic [N_BR*IDX_W-1:0] BR_FROM = '0,
  parameter logic [N_BR*IDX_W-1:0] BR_TO   = '0
) (
  input  logic [N_NODES*W-1:0] node_v,
  output logic [N_BR*W-1:0]    br_v,
  output logic [N_BR-1:0]      br_ovf
);
  localparam logic signed [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};

  // difference with clamp; MSB of the result is the clamp flag
  function automatic logic [W:0] sub_sat(input logic signed [W-1:0] a,
                                         input logic signed [W-1:0] b);
    logic [W:0] d;
    d = {a[W-1], a} - {b[W-1], b};
    if (d[W] != d[W-1]) return {1'b1, (d[W] ? VMIN : VMAX)};
    return {1'b0, d[W-1:0]};
  endfunction

  for (genvar b = 0; b < N_BR; b++) begin : g_br
    localparam int unsigned FI = int'(BR_FROM[b*IDX_W +: IDX_W]);
    localparam int unsigned TI = int'(BR_TO[b*IDX_W +: IDX_W]);
    logic signed [W-1:0] v_from;
    logic signed [W-1:0] v_to;
    if (FI == 0) begin : g_f_gnd
      assign v_from = '0;
    end else begin : g_f_node
      assign v_from = node_v[(FI-1)*W +: W];
    end
    if (TI == 0) begin : g_t_gnd
      assign v_to = '0;
    end else begin : g_t_node
      assign v_to = node_v[(TI-1)*W +: W];
    end
    assign {br_ovf[b], br_v[b*W +: W]} = sub_sat(v_from, v_to);
  end
endmodule

// File: rtl/bre_curr_stage.sv
module bre_curr_stage #(
  parameter int unsigned W    = 34,
  parameter int unsigned F    = 19,
  parameter int unsigned N_BR = 4
) (
  input  logic [N_BR*W-1:0] br_v,
  input  logic [N_BR*W-1:0] br_g,
  input  logic [N_BR*W-1:0] hist_i,
  output logic [N_BR*W-1:0] br_i,
  output logic [N_BR-1:0]   br_ovf
);
  localparam int unsigned PW = 2 * W;
  localparam logic signed [W-1:0]  VMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  VMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [PW-1:0] HI   = {{W{1'b0}}, VMAX};
  localparam logic signed [PW-1:0] LO   = {{W{1'b1}}, VMIN};

  // g*v scaled back by F fractional bits, plus history, clamped
  function automatic logic [W:0] mac_sat(input logic signed [W-1:0] g,
                                         input logic signed [W-1:0] v,
                                         input logic signed [W-1:0] h);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] sh;
    logic signed [PW-1:0] hx;
    logic signed [PW-1:0] s;
    p  = g * v;
    sh = p >>> F;
    hx = {{W{h[W-1]}}, h};
    s  = sh + hx;
    if (s > HI) return {1'b1, VMAX};
    if (s < LO) return {1'b1, VMIN};
    return {1'b0, s[W-1:0]};
  endfunction

  for (genvar b = 0; b < N_BR; b++) begin : g_br
    assign {br_ovf[b], br_i[b*W +: W]} =
      mac_sat(br_g[b*W +: W], br_v[b*W +: W], hist_i[b*W +: W]);
  end
endmodule

// File: rtl/bre_state_bank.sv
module bre_state_bank #(
  parameter int unsigned W    = 34,
  parameter int unsigned N_BR = 4,
  parameter logic [N_BR*W-1:0] INIT_VB = '0,
  parameter logic [N_BR*W-1:0] INIT_IB = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [N_BR*W-1:0] v_in,
  input  logic [N_BR*W-1:0] i_in,
  output logic [N_BR*W-1:0] v_q,
  output logic [N_BR*W-1:0] i_q
);
  for (genvar b = 0; b < N_BR; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[b*W +: W] <= INIT_VB[b*W +: W];
        i_q[b*W +: W] <= INIT_IB[b*W +: W];
      end else if (load) begin
        v_q[b*W +: W] <= v_in[b*W +: W];
        i_q[b*W +: W] <= i_in[b*W +: W];
      end
    end
  end
endmodule

// File: rtl/bre_branch_eval.sv
module bre_branch_eval #(
  parameter int unsigned N_NODES = 3,
  parameter int unsigned N_BR    = 4,
  parameter int unsigned WORD_W  = 34,
  parameter int unsigned FRAC_W  = 19,
  parameter int unsigned IDX_W   = 4,
  parameter logic [N_BR*IDX_W-1:0] BR_FROM = {4'd0, 4'd2, 4'd1, 4'd1},
  parameter logic [N_BR*IDX_W-1:0] BR_TO   = {4'd3, 4'd3, 4'd2, 4'd0},
  parameter logic [N_BR*WORD_W-1:0] INIT_VB =
    {34'h0_0010_0000, 34'h3_FFF8_0000, 34'h0_0004_0000, 34'h0_0008_0000},
  parameter logic [N_BR*WORD_W-1:0] INIT_IB =
    {34'h0_0002_0000, 34'h0_0018_0000, 34'h3_FFF0_0000, 34'h0_000C_0000}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step_go,
  input  logic [N_NODES*WORD_W-1:0] node_v,
  input  logic [N_BR*WORD_W-1:0]    hist_i,
  input  logic [N_BR*WORD_W-1:0]    br_g,
  input  logic                      step_commit,
  output logic                      busy,
  output logic                      res_valid,
  output logic [N_BR*WORD_W-1:0]    br_v,
  output logic [N_BR*WORD_W-1:0]    br_i,
  output logic [N_BR*WORD_W-1:0]    prev_v,
  output logic [N_BR*WORD_W-1:0]    prev_i,
  output logic                      ovf_sticky
);
  import bre_pkg::*;

  localparam int unsigned VW = N_BR * WORD_W;

  bre_phase_e                 phase_q;
  logic [N_NODES*WORD_W-1:0]  cap_nv;
  logic [VW-1:0]              cap_h;
  logic [VW-1:0]              cap_g;
  logic [VW-1:0]              vb_q;
  logic [VW-1:0]              ib_q;
  logic                       res_valid_q;
  logic                       ovf_q;

  logic [VW-1:0]              vb_next;
  logic [VW-1:0]              ib_next;
  logic [N_BR-1:0]            v_ovf;
  logic [N_BR-1:0]            i_ovf;

  // named internal events, used by the bound checker
  logic go_accept;
  logic commit_accept;
  logic ovf_event;

  assign go_accept     = step_go && (phase_q == PH_IDLE);
  assign commit_accept = step_commit && res_valid_q;
  assign ovf_event     = ((phase_q == PH_VOLT) && (|v_ovf)) ||
                         ((phase_q == PH_CURR) && (|i_ovf));

  bre_volt_stage #(
    .W(WORD_W), .N_NODES(N_NODES), .N_BR(N_BR), .IDX_W(IDX_W),
    .BR_FROM(BR_FROM), .BR_TO(BR_TO)
  ) u_volt (
    .node_v (cap_nv),
    .br_v   (vb_next),
    .br_ovf (v_ovf)
  );

  bre_curr_stage #(
    .W(WORD_W), .F(FRAC_W), .N_BR(N_BR)
  ) u_curr (
    .br_v   (vb_q),
    .br_g   (cap_g),
    .hist_i (cap_h),
    .br_i   (ib_next),
    .br_ovf (i_ovf)
  );

  bre_state_bank #(
    .W(WORD_W), .N_BR(N_BR), .INIT_VB(INIT_VB), .INIT_IB(INIT_IB)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .load (commit_accept),
    .v_in (vb_q),
    .i_in (ib_q),
    .v_q  (prev_v),
    .i_q  (prev_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      cap_nv      <= '0;
      cap_h       <= '0;
      cap_g       <= '0;
      vb_q        <= '0;
      ib_q        <= '0;
      res_valid_q <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (go_accept) begin
            cap_nv  <= node_v;
            cap_h   <= hist_i;
            cap_g   <= br_g;
            phase_q <= PH_VOLT;
          end
          if (go_accept || commit_accept) res_valid_q <= 1'b0;
        end
        PH_VOLT: begin
          vb_q    <= vb_next;
          phase_q <= PH_CURR;
        end
        PH_CURR: begin
          ib_q        <= ib_next;
          res_valid_q <= 1'b1;
          phase_q     <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
      if (ovf_event) ovf_q <= 1'b1;
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign res_valid  = res_valid_q;
  assign br_v       = vb_q;
  assign br_i       = ib_q;
  assign ovf_sticky = ovf_q;
endmodule

// File: rtl/bre_checks.sv
module bre_checks #(
  parameter int unsigned W    = 34,
  parameter int unsigned N_BR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              step_go,
  input logic              step_commit,
  input logic              busy,
  input logic              res_valid,
  input logic [1:0]        phase,
  input logic              ovf_event,
  input logic              ovf_sticky,
  input logic [N_BR*W-1:0] br_v,
  input logic [N_BR*W-1:0] br_i,
  input logic [N_BR*W-1:0] prev_v,
  input logic [N_BR*W-1:0] prev_i
);
  // R1: reset leaves the block idle and clean
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && !res_valid && !ovf_sticky));

  // R4: the sticky flag never drops without reset
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_sticky |=> ovf_sticky);

  // R4: the flag only rises after a clamp in one of the stages
  p_sticky_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_sticky) |-> $past(ovf_event));

  // R5: an idle go starts the voltage phase
  p_go_starts_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && step_go) |=> (phase == 2'd1));

  // R5: voltage phase is always followed by current phase
  p_volt_to_curr_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1) |=> (phase == 2'd2));

  // R5: current phase ends with a valid result
  p_curr_to_done_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2) |=> ((phase == 2'd0) && res_valid));

  // R6: while busy no result is presented
  p_busy_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !res_valid);

  // R7: commit copies the result into the delay bank
  p_commit_loads_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && step_commit) |=>
      ((prev_v == $past(br_v)) && (prev_i == $past(br_i)) && !res_valid));

  // R8: without an accepted commit the bank holds
  p_bank_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && step_commit) |=> ($stable(prev_v) && $stable(prev_i)));

  // R9: an uncommitted result is held
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !step_go && !step_commit) |=>
      (res_valid && $stable(br_v) && $stable(br_i)));
endmodule

bind bre_branch_eval bre_checks #(.W(WORD_W), .N_BR(N_BR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .step_go     (step_go),
  .step_commit (step_commit),
  .busy        (busy),
  .res_valid   (res_valid),
  .phase       (phase_q),
  .ovf_event   (ovf_event),
  .ovf_sticky  (ovf_sticky),
  .br_v        (br_v),
  .br_i        (br_i),
  .prev_v      (prev_v),
  .prev_i      (prev_i)
);

// File: tb/sim_bre_branch_eval.sv
module sim_bre_branch_eval;
  localparam int W  = 34;
  localparam int NN = 3;
  localparam int NB = 4;
  localparam int VW = NB * W;
  localparam longint VMAXL = (longint'(1) <<< (W - 1)) - 1;
  localparam longint VMINL = -(longint'(1) <<< (W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_go = 1'b0;
  logic step_commit = 1'b0;
  logic [NN*W-1:0] node_v = '0;
  logic [VW-1:0] hist_i = '0;
  logic [VW-1:0] br_g = '0;
  logic busy, res_valid, ovf_sticky;
  logic [VW-1:0] br_v, br_i, prev_v, prev_i;

  bre_branch_eval u0 (
    .clk(clk), .rst(rst), .step_go(step_go), .node_v(node_v),
    .hist_i(hist_i), .br_g(br_g), .step_commit(step_commit),
    .busy(busy), .res_valid(res_valid), .br_v(br_v), .br_i(br_i),
    .prev_v(prev_v), .prev_i(prev_i), .ovf_sticky(ovf_sticky)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [VW-1:0] v;
    logic [VW-1:0] i;
  } exp_t;
  exp_t sb[$];

  // bench's own view of the topology: from/to node per branch
  int bf[NB] = '{1, 1, 2, 0};
  int bt[NB] = '{0, 2, 3, 3};

  logic [VW-1:0] last_v, last_i, model_pv, model_pi;
  bit have_result = 0;
  bit model_ovf = 0;

  logic signed [W-1:0] a_nv[NN];
  logic signed [W-1:0] a_h[NB];
  logic signed [W-1:0] a_g[NB];

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [W-1:0] q19(input longint milli);
    return W'((milli * 524288) / 1000);
  endfunction

  function automatic logic signed [W-1:0] bsub(input logic signed [W-1:0] a,
      input logic signed [W-1:0] b, inout bit o);
    logic signed [W:0] d;
    d = a - b;
    if (d > VMAXL) begin o = 1; return W'(VMAXL); end
    if (d < VMINL) begin o = 1; return W'(VMINL); end
    return d[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] bmac(input logic signed [W-1:0] g,
      input logic signed [W-1:0] v, input logic signed [W-1:0] h, inout bit o);
    logic signed [2*W-1:0] p;
    logic signed [48:0] t;
    logic signed [49:0] s;
    p = g * v;
    t = p[67:19];
    s = t + h;
    if (s > VMAXL) begin o = 1; return W'(VMAXL); end
    if (s < VMINL) begin o = 1; return W'(VMINL); end
    return s[W-1:0];
  endfunction

  // driver: one full step with timing checks (R5, R6)
  task automatic run_step(input bit poke_busy);
    exp_t e;
    bit o = 0;
    for (int b = 0; b < NB; b++) begin
      logic signed [W-1:0] va, vz, vb, ib;
      va = (bf[b] == 0) ? '0 : a_nv[bf[b]-1];
      vz = (bt[b] == 0) ? '0 : a_nv[bt[b]-1];
      vb = bsub(va, vz, o);
      ib = bmac(a_g[b], vb, a_h[b], o);
      e.v[b*W +: W] = vb;
      e.i[b*W +: W] = ib;
    end
    sb.push_back(e);
    @(negedge clk);
    for (int k = 0; k < NN; k++) node_v[k*W +: W] = a_nv[k];
    for (int b = 0; b < NB; b++) begin
      hist_i[b*W +: W] = a_h[b];
      br_g[b*W +: W]   = a_g[b];
    end
    step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    node_v = ~node_v;  // R6: late input changes must not matter
    hist_i = ~hist_i;
    br_g   = ~br_g;
    chk("R5 busy after go", VW'(busy), VW'(1));
    chk("R5 no result while busy", VW'(res_valid), VW'(0));
    if (poke_busy) step_go = 1'b1;  // R6: go while busy is ignored
    @(negedge clk);
    step_go = 1'b0;
    chk("R5 busy second cycle", VW'(busy), VW'(1));
    chk("R2 br_v one edge after go", br_v, e.v);
    @(negedge clk);
    chk("R5 res_valid two edges after go", VW'(res_valid), VW'(1));
    chk("R6 idle again (busy go ignored)", VW'(busy), VW'(0));
    last_v = e.v;
    last_i = e.i;
    have_result = 1;
    model_ovf = model_ovf | o;
    chk("R4 sticky overflow", VW'(ovf_sticky), VW'(model_ovf));
  endtask

  task automatic do_commit(input string tag);
    @(negedge clk);
    step_commit = 1'b1;
    @(negedge clk);
    step_commit = 1'b0;
    if (have_result) begin
      model_pv = last_v;
      model_pi = last_i;
    end
    have_result = 0;
    chk({tag, " prev_v"}, prev_v, model_pv);
    chk({tag, " prev_i"}, prev_i, model_pi);
    chk({tag, " res_valid cleared"}, VW'(res_valid), VW'(0));
  endtask

  // monitor: compare the scoreboard on each new result (R2, R3)
  initial begin
    logic rv_d = 1'b0;
    forever begin
      @(negedge clk);
      if (res_valid && !rv_d) begin
        if (sb.size() == 0) begin
          chk("R5 unexpected result", VW'(1), VW'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk("R2 branch voltages", br_v, e.v);
          chk("R3 branch currents", br_i, e.i);
        end
      end
      rv_d = res_valid;
    end
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_pv = {34'h0_0010_0000, 34'h3_FFF8_0000, 34'h0_0004_0000, 34'h0_0008_0000};
    model_pi = {34'h0_0002_0000, 34'h0_0018_0000, 34'h3_FFF0_0000, 34'h0_000C_0000};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 prev_v init", prev_v, model_pv);
    chk("R1 prev_i init", prev_i, model_pi);
    chk("R1 idle flags", VW'({busy, res_valid, ovf_sticky}), VW'(0));

    // R8: commit with nothing pending
    do_commit("R8 ignored commit");

    // step A: mixed small values, go poked while busy
    a_nv = '{q19(1500), q19(-250), q19(750)};
    a_h  = '{q19(100), q19(-200), q19(300), q19(0)};
    a_g  = '{q19(2000), q19(500), q19(1250), q19(-1000)};
    run_step(1'b1);
    // R9: result held while idle
    repeat (3) @(negedge clk);
    chk("R9 res_valid held", VW'(res_valid), VW'(1));
    chk("R9 br_v held", br_v, last_v);
    chk("R9 br_i held", br_i, last_i);
    do_commit("R7 commit A");

    // step B: negative voltages, rounding toward minus infinity
    a_nv = '{q19(-3000), q19(4000), q19(-125)};
    a_h  = '{q19(-1000), q19(2500), q19(0), q19(-750)};
    a_g  = '{q19(333), q19(1000), q19(2000), q19(4000)};
    run_step(1'b0);
    do_commit("R7 commit B");
    do_commit("R8 second commit");

    // step C: extremes force clamping on voltage and current
    a_nv = '{34'sh1_FFFF_FFFF, 34'sh2_0000_0000, '0};
    a_h  = '{'0, '0, '0, '0};
    a_g  = '{q19(4000), q19(4000), q19(4000), q19(4000)};
    run_step(1'b0);
    do_commit("R7 commit C");

    // step D: normal values, sticky flag must stay set
    a_nv = '{q19(10), q19(20), q19(-30)};
    a_h  = '{q19(5), q19(-5), q19(1), q19(2)};
    a_g  = '{q19(100), q19(200), q19(300), q19(400)};
    run_step(1'b0);
    chk("R4 sticky after clean step", VW'(ovf_sticky), VW'(1));

    // step E replaces D without commit; bank keeps C
    a_nv = '{q19(-700), q19(0), q19(900)};
    run_step(1'b0);
    chk("R8 bank unchanged by new step", prev_v, model_pv);
    do_commit("R7 commit E");

    repeat (2) @(negedge clk);
    chk("R2 scoreboard drained", VW'(sb.size()), VW'(0));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule